// File: doc/BRIEF.md
# Multi-Chain Logic BIST Engine

This block runs a logic self-test over several parallel scan chains without outside pattern data. A single 16-bit pseudo-random generator supplies one stimulus bit per chain on every shift cycle. Each chain takes its bit from a different position of the generator state. After each load the engine drops scan-enable for a configurable number of functional cycles, so the logic around the chains captures its responses. The next load then shifts those responses out. All chain outputs are folded at once into one multiple-input signature register.

A run starts with a pulse on `start`. The pattern count and the capture length are sampled at that moment. The engine performs one load per pattern and one final unload-only pass. It then raises `done` and shows the signature. In the same cycle it raises `pass` if the signature equals the golden value presented at the end of the run. The engine drives the chain scan-in bits and scan-enable, and it reads the chain scan-out bits. The chains and the logic under test sit outside it.

Top module: `lbist_engine`

## Requirements
- R1: After reset, `done`, `pass` and `scan_en` are 0 and `signature` is 0.
- R2: A `start` pulse in idle or after `done` begins a run. With P = `pat_count` and C' = max(`cap_cycles`, 1), `scan_en` is high for (P+1)·L cycles (L = chain length). Counting the accepting edge as edge 0, `done` rises after edge (P+1)·L + P·C'.
- R3: The generator is a right-shifting Galois register with feedback mask 0xB400 and seed 0xACE1. It is reloaded with the seed on each accepted start and steps once per shift cycle. Chain j receives state bit j·(16/K), where K is the number of chains.
- R4: Between consecutive loads, `scan_en` stays low for exactly C' cycles. A `cap_cycles` value of 0 behaves exactly like 1.
- R5: The signature register is cleared on each accepted start. It updates only on shift cycles after the first load. The update is next = (sig >> 1) ^ (sig[0] ? 0xB400 : 0) ^ so, with chain j's scan-out bit XORed into bit j.
- R6: `pass` rises together with `done`. It is 1 exactly when the final signature equals `golden`.
- R7: A start with `pat_count` = 0 raises `done` one cycle later with signature 0, and `pass` = (`golden` == 0).
- R8: While a run is in progress, `start` and any change to `pat_count` or `cap_cycles` have no effect on the run length or on the signature.
- R9: `done`, `pass` and `signature` hold after completion until the next accepted start. That start clears `done` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle or finished |
| pat_count | input | PCNT_W | Number of patterns, sampled at start |
| cap_cycles | input | CAP_W | Functional cycles per capture, sampled at start (0 acts as 1) |
| golden | input | W | Expected signature, compared at run end |
| chain_so | input | NUM_CHAINS | Scan-out bit of each chain |
| chain_si | output | NUM_CHAINS | Scan-in bit for each chain |
| scan_en | output | 1 | High on shift cycles, low for capture and idle |
| signature | output | W | Compacted signature |
| done | output | 1 | Run finished |
| pass | output | 1 | Signature matched golden |

## Verification
The bench builds the engine with four chains of eight cells and a 3-bit capture length. A complete run therefore takes only tens of cycles, and every capture length from 0 through 7 is reachable. The chains surround a 32-bit combinational mixing function. With each chain tapping a different generator bit, a mis-wired tap, a skipped first-load mask or a wrong capture count changes the 16-bit signature that the bench recomputes. The short runs leave room for random pattern and capture counts alongside the zero-pattern, zero-capture and mid-run-restart cases.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CAPTURE,
        ST_DONE
    } bist_state_e;

    localparam int          DEF_W    = 16;
    localparam logic [15:0] DEF_POLY = 16'hB400;
    localparam logic [15:0] DEF_SEED = 16'hACE1;

endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg #(
    parameter int             W    = 16,
    parameter int             K    = 4,
    parameter logic [W-1:0]   POLY = 16'hB400,
    parameter logic [W-1:0]   SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reload,
    input  logic         advance,
    output logic [K-1:0] chain_si
);
    localparam int STRIDE = W / K;

    typedef struct packed {
        logic [W-1:0] lfsr;
    } prpg_t;

    prpg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reload) begin
            r_d.lfsr = SEED;
        end else if (advance) begin
            r_d.lfsr = {1'b0, r_q.lfsr[W-1:1]} ^ (r_q.lfsr[0] ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.lfsr <= SEED;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar j = 0; j < K; j++) begin : g_tap
        assign chain_si[j] = r_q.lfsr[j*STRIDE];
    end

    // R3: a maximal-length generator seeded nonzero never reaches zero
    a_r3_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.lfsr != '0);

    // R3: state only moves on a reload or a shift step
    a_r3_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && !advance) |=> $stable(r_q.lfsr));

endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
    parameter int           W    = 16,
    parameter int           K    = 4,
    parameter logic [W-1:0] POLY = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         enable,
    input  logic [K-1:0] chain_so,
    output logic [W-1:0] sig,
    output logic [W-1:0] sig_next
);
    typedef struct packed {
        logic [W-1:0] sig;
    } misr_t;

    misr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.sig = '0;
        end else if (enable) begin
            r_d.sig = ({1'b0, r_q.sig[W-1:1]} ^ (r_q.sig[0] ? POLY : '0))
                      ^ {{(W-K){1'b0}}, chain_so};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.sig <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sig      = r_q.sig;
    assign sig_next = r_d.sig;

    // R5: no compaction outside enabled shift cycles
    a_r5_misr_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !enable) |=> $stable(r_q.sig));

    // R5: an accepted start empties the register
    a_r5_misr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (r_q.sig == '0));

endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
    import lbist_pkg::*;
#(
    parameter int L      = 8,
    parameter int PCNT_W = 8,
    parameter int CAP_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PCNT_W-1:0] pat_count,
    input  logic [CAP_W-1:0]  cap_cycles,
    output logic              scan_en,
    output logic              accept,
    output logic              gen_advance,
    output logic              cmp_enable,
    output logic              finish,
    output logic              done
);
    localparam int              BCW  = (L > 1) ? $clog2(L) : 1;
    localparam logic [BCW-1:0]  LAST = BCW'(L - 1);

    typedef struct packed {
        bist_state_e       state;
        logic [BCW-1:0]    bit_cnt;
        logic [PCNT_W-1:0] loads;
        logic [CAP_W-1:0]  cap_cfg;
        logic [CAP_W-1:0]  cap_cnt;
        logic              first;
        logic              done;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        accept      = 1'b0;
        gen_advance = 1'b0;
        cmp_enable  = 1'b0;
        finish      = 1'b0;

        unique case (r_q.state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    accept      = 1'b1;
                    r_d.done    = 1'b0;
                    r_d.first   = 1'b1;
                    r_d.bit_cnt = '0;
                    r_d.loads   = pat_count;
                    r_d.cap_cfg = (cap_cycles == '0) ? CAP_W'(1) : cap_cycles;
                    if (pat_count == '0) begin
                        r_d.state = ST_DONE;
                        r_d.done  = 1'b1;
                        finish    = 1'b1;
                    end else begin
                        r_d.state = ST_SHIFT;
                    end
                end
            end
            ST_SHIFT: begin
                gen_advance = 1'b1;
                cmp_enable  = !r_q.first;
                if (r_q.bit_cnt == LAST) begin
                    r_d.bit_cnt = '0;
                    if (r_q.loads == '0) begin
                        r_d.state = ST_DONE;
                        r_d.done  = 1'b1;
                        finish    = 1'b1;
                    end else begin
                        r_d.state   = ST_CAPTURE;
                        r_d.loads   = r_q.loads - 1'b1;
                        r_d.first   = 1'b0;
                        r_d.cap_cnt = r_q.cap_cfg;
                    end
                end else begin
                    r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                end
            end
            ST_CAPTURE: begin
                if (r_q.cap_cnt == CAP_W'(1)) begin
                    r_d.state   = ST_SHIFT;
                    r_d.bit_cnt = '0;
                end else begin
                    r_d.cap_cnt = r_q.cap_cnt - 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.bit_cnt <= '0;
            r_q.loads   <= '0;
            r_q.cap_cfg <= CAP_W'(1);
            r_q.cap_cnt <= CAP_W'(1);
            r_q.first   <= 1'b1;
            r_q.done    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign scan_en = (r_q.state == ST_SHIFT);
    assign done    = r_q.done;

    // R2: a load is never cut short
    a_r2_shift_run: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SHIFT && r_q.bit_cnt != LAST) |=> (r_q.state == ST_SHIFT));

    // R4: capture leads only back to shifting
    a_r4_capture_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CAPTURE) |=> (r_q.state == ST_CAPTURE || r_q.state == ST_SHIFT));

    // R7: an empty run completes on the next cycle
    a_r7_empty_run: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pat_count == '0) |=> done);

    // R8: start while busy does not disturb the count of remaining loads
    a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CAPTURE && r_q.cap_cnt != CAP_W'(1)) |=> $stable(r_q.loads));

    // R9: a finished run stays finished until a start arrives
    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

// File: rtl/lbist_engine.sv
module lbist_engine
    import lbist_pkg::*;
#(
    parameter int           NUM_CHAINS = 4,
    parameter int           CHAIN_LEN  = 8,
    parameter int           W          = DEF_W,
    parameter logic [W-1:0] POLY       = DEF_POLY,
    parameter logic [W-1:0] SEED       = DEF_SEED,
    parameter int           PCNT_W     = 8,
    parameter int           CAP_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [PCNT_W-1:0]     pat_count,
    input  logic [CAP_W-1:0]      cap_cycles,
    input  logic [W-1:0]          golden,
    input  logic [NUM_CHAINS-1:0] chain_so,
    output logic [NUM_CHAINS-1:0] chain_si,
    output logic                  scan_en,
    output logic [W-1:0]          signature,
    output logic                  done,
    output logic                  pass
);
    typedef struct packed {
        logic pass;
    } top_t;

    top_t r_d, r_q;

    logic         accept;
    logic         gen_advance;
    logic         cmp_enable;
    logic         finish;
    logic [W-1:0] sig_next;

    lbist_ctrl #(
        .L      (CHAIN_LEN),
        .PCNT_W (PCNT_W),
        .CAP_W  (CAP_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .pat_count   (pat_count),
        .cap_cycles  (cap_cycles),
        .scan_en     (scan_en),
        .accept      (accept),
        .gen_advance (gen_advance),
        .cmp_enable  (cmp_enable),
        .finish      (finish),
        .done        (done)
    );

    lbist_prpg #(
        .W    (W),
        .K    (NUM_CHAINS),
        .POLY (POLY),
        .SEED (SEED)
    ) u_prpg (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (accept),
        .advance  (gen_advance),
        .chain_si (chain_si)
    );

    lbist_misr #(
        .W    (W),
        .K    (NUM_CHAINS),
        .POLY (POLY)
    ) u_misr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .enable   (cmp_enable),
        .chain_so (chain_so),
        .sig      (signature),
        .sig_next (sig_next)
    );

    always_comb begin
        r_d = r_q;
        if (accept) begin
            r_d.pass = 1'b0;
        end
        if (finish) begin
            r_d.pass = (sig_next == golden);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.pass <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pass = r_q.pass;

    // R6: a pass verdict only exists alongside completion
    a_r6_pass_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

    // R2: no shifting after completion
    a_r2_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !scan_en);

    // R9: the signature stays put while finished and no start arrives
    a_r9_sig_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(signature));

endmodule

// File: tb/lbist_engine_test.sv
`timescale 1ns/1ps
module lbist_engine_test;
    localparam int K  = 4;
    localparam int L  = 8;
    localparam int N  = K * L;
    localparam int PW = 8;
    localparam int CW = 3;
    localparam logic [15:0] SEED_V = 16'hACE1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [PW-1:0] pat_count = '0;
    logic [CW-1:0] cap_cycles = '0;
    logic [15:0]   golden = '0;
    logic [K-1:0]  chain_so;
    logic [K-1:0]  chain_si;
    logic          scan_en;
    logic [15:0]   signature;
    logic          done;
    logic          pass;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lbist_engine #(
        .NUM_CHAINS (K),
        .CHAIN_LEN  (L),
        .PCNT_W     (PW),
        .CAP_W      (CW)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .pat_count  (pat_count),
        .cap_cycles (cap_cycles),
        .golden     (golden),
        .chain_so   (chain_so),
        .chain_si   (chain_si),
        .scan_en    (scan_en),
        .signature  (signature),
        .done       (done),
        .pass       (pass)
    );

    // ---------------- reference functions ----------------
    function automatic logic [15:0] g16(input logic [15:0] s);
        return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    function automatic logic [N-1:0] cut_f(input logic [N-1:0] s);
        logic [N-1:0] nx;
        for (int i = 0; i < N; i++)
            nx[i] = s[i] ^ (s[(i+1)%N] & ~s[(i+5)%N]) ^ s[(i+11)%N];
        return nx;
    endfunction

    function automatic logic [N-1:0] shift_f(input logic [N-1:0] s, input logic [K-1:0] si);
        logic [N-1:0] nx;
        for (int j = 0; j < K; j++) begin
            for (int b = L-1; b > 0; b--) nx[j*L+b] = s[j*L+b-1];
            nx[j*L] = si[j];
        end
        return nx;
    endfunction

    function automatic logic [15:0] model_sig(input int p, input int c);
        logic [15:0]  lf;
        logic [15:0]  m;
        logic [N-1:0] st;
        logic [K-1:0] so;
        logic [K-1:0] si;
        int           cc;
        lf = SEED_V;
        m  = '0;
        st = '0;
        cc = (c == 0) ? 1 : c;
        for (int ld = 0; ld <= p; ld++) begin
            for (int b = 0; b < L; b++) begin
                for (int j = 0; j < K; j++) begin
                    so[j] = st[j*L+L-1];
                    si[j] = lf[j*(16/K)];
                end
                if (ld > 0) m = g16(m) ^ {{(16-K){1'b0}}, so};
                st = shift_f(st, si);
                lf = g16(lf);
            end
            if (ld < p)
                for (int q = 0; q < cc; q++) st = cut_f(st);
        end
        return m;
    endfunction

    function automatic int model_cycles(input int p, input int c);
        return (p + 1) * L + p * ((c == 0) ? 1 : c);
    endfunction

    // ---------------- chains around the logic under test ----------------
    logic [N-1:0] st_h = '0;
    always_ff @(posedge clk) st_h <= scan_en ? shift_f(st_h, chain_si) : cut_f(st_h);
    always_comb
        for (int j = 0; j < K; j++) chain_so[j] = st_h[j*L+L-1];

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    int  r_cyc;
    int  r_shifts;
    bit  r_si_bad;

    task automatic run(input int p, input int c, input logic [15:0] g, input bit midstart);
        logic [15:0] lf;
        @(negedge clk);
        pat_count  = PW'(p);
        cap_cycles = CW'(c);
        golden     = g;
        start      = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        r_cyc    = 0;
        r_shifts = 0;
        r_si_bad = 0;
        lf       = SEED_V;
        while (!done && r_cyc < 3000) begin
            if (scan_en) r_shifts++;
            if (p > 0 && r_cyc < L) begin
                for (int j = 0; j < K; j++)
                    if (chain_si[j] !== lf[j*(16/K)]) r_si_bad = 1;
                lf = g16(lf);
            end
            if (midstart && r_cyc == 3) begin
                start      = 1'b1;
                pat_count  = PW'(p + 3);
                cap_cycles = CW'(c + 2);
            end
            if (midstart && r_cyc == 4) start = 1'b0;
            @(posedge clk);
            @(negedge clk);
            r_cyc++;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [15:0] e;
        logic [15:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 1'b0,      "R1", "done after reset",    32'(done), 0);
        chk(pass == 1'b0,      "R1", "pass after reset",    32'(pass), 0);
        chk(scan_en == 1'b0,   "R1", "scan_en after reset", 32'(scan_en), 0);
        chk(signature == 16'h0,"R1", "signature after reset", 32'(signature), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed: 3 patterns, 2 capture cycles, wrong golden
        e = model_sig(3, 2);
        run(3, 2, 16'h0000, 0);
        chk(r_cyc == model_cycles(3, 2), "R2", "run length", 32'(r_cyc), 32'(model_cycles(3, 2)));
        chk(r_shifts == 4 * L,           "R2", "shift cycles", 32'(r_shifts), 32'(4 * L));
        chk(r_si_bad == 0,               "R3", "chain_si taps in first load", 32'(r_si_bad), 0);
        chk(signature == e,              "R5", "signature p3 c2", 32'(signature), 32'(e));
        chk(pass == (e == 16'h0),        "R6", "pass vs golden 0", 32'(pass), 32'(e == 16'h0));
        // R9 hold
        held = signature;
        repeat (5) @(negedge clk);
        chk(done == 1'b1 && signature == held, "R9", "done/signature hold",
            {15'b0, done, held ^ signature}, {15'b0, 1'b1, 16'h0});

        // R6 matching golden; R9 start clears done
        @(negedge clk);
        pat_count = 3; cap_cycles = 2; golden = e; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R9", "done cleared after restart", 32'(done), 0);
        while (!done) @(negedge clk);
        chk(pass == 1'b1, "R6", "pass with matching golden", 32'(pass), 1);
        chk(signature == e, "R5", "signature repeatable", 32'(signature), 32'(e));

        // R4 capture of 0 behaves as 1
        e = model_sig(2, 1);
        run(2, 0, e, 0);
        chk(signature == e, "R4", "cap 0 signature equals cap 1", 32'(signature), 32'(e));
        chk(r_cyc == model_cycles(2, 1), "R4", "cap 0 run length", 32'(r_cyc), 32'(model_cycles(2, 1)));
        chk(pass == 1'b1, "R6", "pass after cap 0 run", 32'(pass), 1);

        // R4 long capture changes the response
        e = model_sig(2, 7);
        run(2, 7, 16'h0000, 0);
        chk(signature == e, "R4", "cap 7 signature", 32'(signature), 32'(e));
        chk(r_cyc == model_cycles(2, 7), "R4", "cap 7 run length", 32'(r_cyc), 32'(model_cycles(2, 7)));

        // R7 empty run
        run(0, 3, 16'h0000, 0);
        chk(r_cyc == 0, "R7", "empty run completes at once", 32'(r_cyc), 0);
        chk(signature == 16'h0, "R7", "empty run signature", 32'(signature), 0);
        chk(pass == 1'b1, "R7", "empty run pass with golden 0", 32'(pass), 1);
        run(0, 3, 16'h0001, 0);
        chk(pass == 1'b0, "R7", "empty run fail with golden 1", 32'(pass), 0);

        // R8 start and config change during a run
        e = model_sig(2, 3);
        run(2, 3, e, 1);
        chk(r_cyc == model_cycles(2, 3), "R8", "run length unaffected", 32'(r_cyc), 32'(model_cycles(2, 3)));
        chk(signature == e, "R8", "signature unaffected", 32'(signature), 32'(e));
        chk(pass == 1'b1, "R8", "pass unaffected", 32'(pass), 1);

        // random runs
        for (int t = 0; t < 12; t++) begin
            int          p;
            int          c;
            bit          good;
            logic [15:0] g;
            p    = 1 + ($urandom % 6);
            c    = $urandom % 8;
            good = $urandom % 2;
            e    = model_sig(p, c);
            g    = good ? e : (e ^ 16'h0100);
            run(p, c, g, 0);
            chk(signature == e, "R5", "random signature", 32'(signature), 32'(e));
            chk(r_cyc == model_cycles(p, c), "R2", "random run length", 32'(r_cyc), 32'(model_cycles(p, c)));
            chk(pass == good, "R6", "random pass", 32'(pass), 32'(good));
            chk(r_si_bad == 0, "R3", "random chain_si taps", 32'(r_si_bad), 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule